// File: doc/BRIEF.md
# Programmable-Timing Expansion ROM Byte Reader

This block reads single bytes from an external parallel Flash or EPROM. A host presents a 20-bit byte address on a valid/ready request channel. The block drives that address onto the ROM pins and holds chip-enable and output-enable active for a programmed number of ROM-clock periods. It then samples the 8-bit data bus and returns the byte on a one-cycle response strobe.

The ROM clock is the fast input clock divided by four. The divider restarts whenever a read is accepted, so every hold interval begins on a ROM-clock boundary. A 4-bit timing register sets the hold interval. Hard reset loads it with 9. Soft reset and a stop command leave it unchanged, although either one abandons a read that is in progress. A stored value of zero is not supported: it is flagged and the read runs as if the value were 1.

Back-pressure applies only on the request side. `req_ready` is high exactly when no read is in flight, and a request is taken on a clock edge where both `req_valid` and `req_ready` are high. The response channel has no ready input, so the consumer must take `rsp_data` in the cycle where `rsp_valid` is high.

Top module: `rom_reader`

## Requirements
- R1: `busy` is the inverse of `req_ready`. A request presented while `busy` is high is ignored: it produces no response and does not change `rom_addr`.
- R2: While a read is in flight, `rom_ce_n` and `rom_oe_n` are both low and `rom_addr` holds the accepted address unchanged. When idle, both enables are high.
- R3: `rsp_valid` rises exactly 4*N fast-clock cycles after the accepting edge, where N is the effective timing value. `busy` falls at the same edge.
- R4: `rsp_data` equals the value on `rom_data` at the final edge of the hold interval.
- R5: After hard reset (`rst_n` low), the timing field is 9, so a read takes 36 cycles. `tmg_illegal` is low, `req_ready` is high and `rsp_valid` is low.
- R6: A write of 0 to the timing field sets `tmg_illegal` high from the next cycle on, and reads then use N=1. A non-zero write clears `tmg_illegal`.
- R7: A `soft_rst` or `stop_cmd` pulse leaves the timing field unchanged. It abandons any read in flight: `busy` is low after the edge and no response follows.
- R8: The timing field is sampled when a read is accepted. A write to it during a read does not change that read's length.
- R9: `rom_clk` is low for two fast cycles and then high for two, with the low phase starting at each accepted read.
- R10: `rsp_valid` is high for exactly one cycle per completed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast expansion clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous |
| soft_rst | input | 1 | Soft reset pulse; abandons the current read |
| stop_cmd | input | 1 | Stop command pulse; abandons the current read |
| tmg_we | input | 1 | Write strobe for the timing field |
| tmg_wdata | input | 4 | New timing value in ROM-clock cycles |
| tmg_illegal | output | 1 | Stored timing value is zero (treated as 1) |
| req_valid | input | 1 | Read request valid |
| req_addr | input | 20 | Byte address for the request |
| req_ready | output | 1 | Block can accept a request |
| busy | output | 1 | A read is in flight |
| rsp_valid | output | 1 | One-cycle strobe: read data is valid |
| rsp_data | output | 8 | Byte read from the ROM |
| rom_clk | output | 1 | Divided ROM clock (fast clock / 4) |
| rom_addr | output | 20 | Address driven to the ROM |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_data | input | 8 | ROM data bus |

## Verification
The bench measures each read's latency from the accepting edge at the ports. The extreme timing values 1, 15 and 0 expose a design whose count is off by one, or one that wraps when it decrements from zero and hangs or runs for 16 ROM-clock periods. The bench rewrites the timing field in the middle of a read, which catches a design that uses the live register instead of the value captured at the start. It also presents a request while busy, which catches a design that lets the ROM address move in the middle of a read or sends a second response. Soft reset, stop and hard reset are each followed by a timed read. A design that reloaded the default on the wrong reset, or that finished an abandoned read, shows up as a wrong latency or as a response nobody asked for.

// File: rtl/rom_reader_pkg.sv
package rom_reader_pkg;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 8;
  localparam int TMG_W  = 4;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HOLD = 1'b1
  } rd_state_t;
endpackage

// File: rtl/rom_clk_div.sv
module rom_clk_div #(
  parameter int RATIO = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick,
  output logic slow_clk
);
  localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);
  localparam logic [CW-1:0] HALF = CW'(RATIO / 2);

  logic [CW-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          phase <= '0;
    else if (restart)    phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                 phase <= phase + 1'b1;
  end

  assign tick     = (phase == LAST);
  assign slow_clk = (phase >= HALF);
endmodule

// File: rtl/rom_tmg_reg.sv
module rom_tmg_reg #(
  parameter int TW = 4,
  parameter logic [TW-1:0] RST_VAL = 4'b1001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [TW-1:0] wdata,
  output logic [TW-1:0] eff,
  output logic          illegal
);
  logic [TW-1:0] field;

  // Only the hard reset touches this field; soft reset and stop do not reach it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  field <= RST_VAL;
    else if (we) field <= wdata;
  end

  assign illegal = (field == '0);
  assign eff     = illegal ? TW'(1) : field;
endmodule

// File: rtl/rom_hold_ctrl.sv
module rom_hold_ctrl
  import rom_reader_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int TW = TMG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          tick,
  input  logic [TW-1:0] tmg_eff,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          start,
  output logic          in_flight,
  output logic [AW-1:0] addr_q,
  input  logic [DW-1:0] rom_data,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  rd_state_t     state;
  logic [TW-1:0] remain;
  logic          last_tick;

  assign in_flight = (state == ST_HOLD);
  assign start     = !in_flight && req_valid && !abort;
  assign last_tick = in_flight && tick && (remain == TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      remain    <= '0;
      addr_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (abort) begin
        state <= ST_IDLE;
      end else if (start) begin
        state  <= ST_HOLD;
        addr_q <= req_addr;
        remain <= tmg_eff;
      end else if (last_tick) begin
        state     <= ST_IDLE;
        rsp_data  <= rom_data;
        rsp_valid <= 1'b1;
      end else if (in_flight && tick) begin
        remain <= remain - 1'b1;
      end
    end
  end
endmodule

// File: rtl/rom_reader.sv
module rom_reader
  import rom_reader_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int TW = TMG_W,
  parameter int CLK_RATIO = 4,
  parameter logic [TW-1:0] TMG_RST = 4'b1001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          stop_cmd,
  input  logic          tmg_we,
  input  logic [TW-1:0] tmg_wdata,
  output logic          tmg_illegal,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          req_ready,
  output logic          busy,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rom_clk,
  output logic [AW-1:0] rom_addr,
  output logic          rom_ce_n,
  output logic          rom_oe_n,
  input  logic [DW-1:0] rom_data
);
  logic          abort;
  logic          start;
  logic          tick;
  logic          in_flight;
  logic [TW-1:0] tmg_eff;

  assign abort = soft_rst | stop_cmd;

  rom_clk_div #(.RATIO(CLK_RATIO)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (start),
    .tick     (tick),
    .slow_clk (rom_clk)
  );

  rom_tmg_reg #(.TW(TW), .RST_VAL(TMG_RST)) u_tmg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (tmg_we),
    .wdata   (tmg_wdata),
    .eff     (tmg_eff),
    .illegal (tmg_illegal)
  );

  rom_hold_ctrl #(.AW(AW), .DW(DW), .TW(TW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (abort),
    .tick      (tick),
    .tmg_eff   (tmg_eff),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .start     (start),
    .in_flight (in_flight),
    .addr_q    (rom_addr),
    .rom_data  (rom_data),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  assign busy      = in_flight;
  assign req_ready = !in_flight;
  assign rom_ce_n  = !in_flight;
  assign rom_oe_n  = !in_flight;
endmodule

// File: rtl/rom_reader_chk.sv
module rom_reader_chk #(
  parameter int AW = 20,
  parameter int TW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          soft_rst,
  input logic          stop_cmd,
  input logic          tmg_we,
  input logic [TW-1:0] tmg_wdata,
  input logic          tmg_illegal,
  input logic          req_ready,
  input logic          busy,
  input logic          rsp_valid,
  input logic          rom_clk,
  input logic [AW-1:0] rom_addr,
  input logic          rom_ce_n,
  input logic          rom_oe_n
);
  assert_hold_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  assert_enables_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!rom_ce_n && !rom_oe_n));

  assert_idle_enables_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rom_ce_n && rom_oe_n));

  assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(rom_addr));

  assert_rsp_ends_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(busy) && !busy));

  assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tmg_we && tmg_wdata == '0) |=> tmg_illegal);

  assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst || stop_cmd) |=> (!busy && !rsp_valid));

  assert_rom_clk_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_clk && $past(rom_clk)) |=> !rom_clk);

  assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind rom_reader rom_reader_chk #(.AW(AW), .TW(TW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .soft_rst    (soft_rst),
  .stop_cmd    (stop_cmd),
  .tmg_we      (tmg_we),
  .tmg_wdata   (tmg_wdata),
  .tmg_illegal (tmg_illegal),
  .req_ready   (req_ready),
  .busy        (busy),
  .rsp_valid   (rsp_valid),
  .rom_clk     (rom_clk),
  .rom_addr    (rom_addr),
  .rom_ce_n    (rom_ce_n),
  .rom_oe_n    (rom_oe_n)
);

// File: tb/sim_rom_reader.sv
module sim_rom_reader;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0, stop_cmd = 1'b0;
  logic        tmg_we = 1'b0;
  logic [3:0]  tmg_wdata = '0;
  logic        tmg_illegal;
  logic        req_valid = 1'b0;
  logic [19:0] req_addr = '0;
  logic        req_ready, busy, rsp_valid, rom_clk, rom_ce_n, rom_oe_n;
  logic [7:0]  rsp_data, rom_data;
  logic [19:0] rom_addr;

  int n_vec = 0, n_bad = 0, cyc = 0;
  int exp_cyc_q[$];
  logic [7:0] exp_dat_q[$];
  logic [19:0] cur_addr = '0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // ROM model: byte depends on address
  function automatic logic [7:0] rom_byte(input logic [19:0] a);
    return a[7:0] ^ a[19:12] ^ 8'h5A;
  endfunction
  assign rom_data = rom_byte(rom_addr);

  rom_reader u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop_cmd(stop_cmd),
    .tmg_we(tmg_we), .tmg_wdata(tmg_wdata), .tmg_illegal(tmg_illegal),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rom_clk(rom_clk), .rom_addr(rom_addr), .rom_ce_n(rom_ce_n),
    .rom_oe_n(rom_oe_n), .rom_data(rom_data)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // Monitor: pops expected responses, checks ROM pins during reads
  always @(negedge clk) begin
    if (rst_n && busy) begin
      check(!rom_ce_n && !rom_oe_n, "R2 enables low while busy", {rom_ce_n, rom_oe_n}, 0);
      check(rom_addr == cur_addr, "R2 address held", rom_addr, cur_addr);
    end
    if (rst_n && rsp_valid) begin
      if (exp_cyc_q.size() == 0) begin
        check(0, "R1/R7 unexpected response", rsp_data, -1);
      end else begin
        int ec;
        logic [7:0] ed;
        ec = exp_cyc_q.pop_front();
        ed = exp_dat_q.pop_front();
        check(cyc == ec, "R3 response latency", cyc, ec);
        check(rsp_data == ed, "R4 response data", rsp_data, ed);
      end
    end
  end

  task automatic write_tmg(input logic [3:0] v);
    @(negedge clk);
    tmg_we = 1'b1; tmg_wdata = v;
    @(negedge clk);
    tmg_we = 1'b0;
  endtask

  // Driver: issue request; push expectation when push is set
  task automatic start_read(input logic [19:0] a, input int n, input bit push);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(posedge clk); #1;
    req_valid = 1'b0;
    cur_addr = a;
    if (push) begin
      exp_cyc_q.push_back(cyc + 4*n);
      exp_dat_q.push_back(rom_byte(a));
    end
  endtask

  task automatic wait_done();
    while (exp_cyc_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic do_read(input logic [19:0] a, input int n);
    start_read(a, n, 1);
    wait_done();
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) soft_rst = 1'b1; else stop_cmd = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0; stop_cmd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog expired", cyc, 0);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R5 reset state
    check(req_ready && !busy, "R5 ready after reset", req_ready, 1);
    check(!rsp_valid, "R5 no response after reset", rsp_valid, 0);
    check(rom_ce_n && rom_oe_n, "R2 enables idle after reset", {rom_ce_n, rom_oe_n}, 3);
    check(!tmg_illegal, "R5 flag clear after reset", tmg_illegal, 0);
    // R5 default timing 9 -> 36 cycles
    do_read(20'h12345, 9);
    do_read(20'hFFFFF, 9);
    // R9 rom_clk phase after accept
    start_read(20'h00A00, 9, 1);
    @(negedge clk); check(!rom_clk, "R9 rom_clk low phase 0", rom_clk, 0);
    @(negedge clk); check(!rom_clk, "R9 rom_clk low phase 1", rom_clk, 0);
    @(negedge clk); check(rom_clk,  "R9 rom_clk high phase 2", rom_clk, 1);
    @(negedge clk); check(rom_clk,  "R9 rom_clk high phase 3", rom_clk, 1);
    @(negedge clk); check(!rom_clk, "R9 rom_clk low again", rom_clk, 0);
    // R1 request while busy is ignored
    check(!req_ready && busy, "R1 busy during read", req_ready, 0);
    req_valid = 1'b1; req_addr = 20'h0BEEF;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    check(!busy, "R1 held-off request not started", busy, 0);
    // boundary values
    write_tmg(4'd1);
    do_read(20'h00001, 1);
    write_tmg(4'd15);
    do_read(20'h80000, 15);
    // R6 zero is clamped and flagged
    write_tmg(4'd0);
    check(tmg_illegal, "R6 zero flagged", tmg_illegal, 1);
    do_read(20'h0F0F0, 1);
    write_tmg(4'd2);
    check(!tmg_illegal, "R6 flag cleared", tmg_illegal, 1'b0);
    do_read(20'h33333, 2);
    // R8 write during read does not affect it
    write_tmg(4'd3);
    start_read(20'h44444, 3, 1);
    write_tmg(4'd7);
    wait_done();
    do_read(20'h55555, 7);
    // R7 soft reset and stop keep the field
    write_tmg(4'd5);
    pulse(0);
    do_read(20'h66666, 5);
    pulse(1);
    do_read(20'h77777, 5);
    // R7 abort mid-read: no response
    start_read(20'h88888, 5, 0);
    repeat (5) @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    check(!busy && req_ready, "R7 soft reset abandons read", busy, 0);
    check(rom_ce_n, "R7 enables released", rom_ce_n, 1);
    repeat (30) @(negedge clk);
    start_read(20'h99999, 5, 0);
    repeat (3) @(negedge clk);
    stop_cmd = 1'b1;
    @(negedge clk);
    stop_cmd = 1'b0;
    check(!busy, "R7 stop abandons read", busy, 0);
    repeat (30) @(negedge clk);
    do_read(20'hAAAAA, 5);
    // R5 hard reset restores 9
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    do_read(20'hCCCCC, 9);
    // R10 single-cycle response
    start_read(20'hDDDDD, 9, 1);
    wait (rsp_valid);
    @(negedge clk);
    @(negedge clk);
    check(!rsp_valid, "R10 response lasts one cycle", rsp_valid, 0);
    wait_done();
    finish_up();
  end
endmodule